// File: doc/BRIEF.md
# Operand Effective Address Generator

This unit turns the addressing fields of one instruction into the value the operand stage needs. It handles a register-direct selector, an immediate taken from the instruction, a pointer register used as an address with or without post-increment, a pointer plus a sign-extended 8-bit displacement, a pointer plus an unsigned 16-bit displacement, and the stack accesses of push and pop. Its result is either an effective address or an immediate value. Where the mode changes a register, it also gives the pointer write-back and the new stack pointer.

The unit is purely combinational and sits between instruction decode and the register file and memory ports. The register file reads the word register named by the selector and presents it on `ptr_i`. The unit returns the address and any write-back in the same cycle. If a register selector breaks the alignment rule of its operand type, an error flag goes high and every write-back enable is held low. This keeps the architectural state untouched by a faulting operand.

Top module: `eag_top`

## Requirements
- R1: Mode encoding is 0 direct, 1 immediate, 2 indirect, 3 indirect with post-increment, 4 short indexed, 5 long indexed, 6 push, 7 pop; `size_i` is 0 for byte and 1 for word. In direct mode `addr_o` is the selector zero-extended to 16 bits, `imm_valid_o`, `ptr_wb_en_o` and `sp_we_o` are 0, and `sp_o` equals `sp_i`.
- R2: `align_err_o` is 1 when a word direct operand has an odd selector, when any of modes 2 to 5 has an odd selector (the pointer is a word register), or when push or pop sees an odd `sp_i`. It is 0 for byte direct operands and for immediates.
- R3: In immediate mode `imm_valid_o` is 1 and `addr_o` carries the immediate. For a byte this is `field_i[7:0]` zero-extended, and for a word it is all of `field_i`. No write-back enable is raised.
- R4: In indirect mode `addr_o` equals `ptr_i` and no write-back enable is raised.
- R5: In post-increment mode `addr_o` equals `ptr_i`. `ptr_wb_en_o` is 1 and `ptr_wb_o` is `ptr_i` plus 2 for a word or plus 1 for a byte.
- R6: In short indexed mode `addr_o` is `ptr_i` plus `field_i[7:0]` sign-extended. This reaches from 128 below to 127 above the pointer, and `field_i[15:8]` is ignored.
- R7: In long indexed mode `addr_o` is `ptr_i` plus `field_i`, with no sign extension.
- R8: A push gives `addr_o` equal to `sp_i` minus 2, with `sp_o` at that same value and `sp_we_o` at 1.
- R9: A pop gives `addr_o` equal to `sp_i`, with `sp_o` at `sp_i` plus 2 and `sp_we_o` at 1.
- R10: Every address and pointer sum wraps modulo 2^16.
- R11: While `align_err_o` is 1, `ptr_wb_en_o` and `sp_we_o` are both 0 and `sp_o` equals `sp_i`.
- R12: A post-increment on selector 18H, the stack pointer's register address, also raises `sp_we_o`, and `sp_o` equals `ptr_wb_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mode_i | input | 3 | Addressing mode code |
| size_i | input | 1 | Operand size, 0 byte, 1 word |
| reg_sel_i | input | 8 | Register selector from the instruction |
| ptr_i | input | 16 | Word register value read at the selector |
| field_i | input | 16 | Immediate or displacement field |
| sp_i | input | 16 | Current stack pointer |
| addr_o | output | 16 | Effective address or immediate value |
| imm_valid_o | output | 1 | `addr_o` holds an immediate |
| ptr_wb_o | output | 16 | Post-incremented pointer value |
| ptr_wb_en_o | output | 1 | Write `ptr_wb_o` back to the selected register |
| sp_o | output | 16 | Next stack pointer |
| sp_we_o | output | 1 | Stack pointer update enable |
| align_err_o | output | 1 | Operand alignment violation |

## Verification
Some properties are checked on every input combination. An alignment error always blocks both write-back enables and holds the stack pointer, and an immediate never writes back or faults. A stack update always moves the pointer by exactly two in the right direction, and a short indexed address always stays within the signed byte window of the pointer. Only the bench scenarios can show the actual values: the byte and word immediate widths, the post-increment step per size, and the long-indexed sum done without sign extension. The bench scenarios also cover wrap-around at both ends of the address space, the stack pointer alias at selector 18H, and the full sweep of short displacements.

// File: rtl/eag_pkg.sv
package eag_pkg;
  typedef enum logic [2:0] {
    MODE_DIRECT = 3'd0,
    MODE_IMM    = 3'd1,
    MODE_IND    = 3'd2,
    MODE_INDINC = 3'd3,
    MODE_SHORT  = 3'd4,
    MODE_LONG   = 3'd5,
    MODE_PUSH   = 3'd6,
    MODE_POP    = 3'd7
  } mode_e;

  localparam int BYTE_W = 8;
endpackage

// File: rtl/eag_align_chk.sv
module eag_align_chk
  import eag_pkg::*;
#(
  parameter int SEL_W = 8
) (
  input  mode_e            mode_i,
  input  logic             size_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             sp_lsb_i,
  output logic             err_o
);
  always_comb begin
    unique case (mode_i)
      MODE_DIRECT:                  err_o = size_i & sel_i[0];
      MODE_IMM:                     err_o = 1'b0;
      MODE_IND, MODE_INDINC,
      MODE_SHORT, MODE_LONG:        err_o = sel_i[0]; // pointer is a word register
      MODE_PUSH, MODE_POP:          err_o = sp_lsb_i;
      default:                      err_o = 1'b0;
    endcase
  end

  always_comb begin
    assert_imm_never_faults_R2: assert (mode_i != MODE_IMM || !err_o);
  end
endmodule

// File: rtl/eag_index_add.sv
module eag_index_add
  import eag_pkg::*;
#(
  parameter int AW      = 16,
  parameter int SHORT_W = 8,
  parameter int WORD_BYTES = 2
) (
  input  mode_e         mode_i,
  input  logic          size_i,
  input  logic [AW-1:0] ptr_i,
  input  logic [AW-1:0] field_i,
  output logic [AW-1:0] addr_o,
  output logic [AW-1:0] inc_o
);
  localparam int EXT_W = AW - SHORT_W;

  logic [AW-1:0] disp;
  logic [AW-1:0] step;

  always_comb begin
    unique case (mode_i)
      MODE_SHORT: disp = {{EXT_W{field_i[SHORT_W-1]}}, field_i[SHORT_W-1:0]};
      MODE_LONG:  disp = field_i;
      default:    disp = '0;
    endcase
  end

  assign addr_o = ptr_i + disp;
  assign step   = size_i ? AW'(WORD_BYTES) : AW'(1);
  assign inc_o  = ptr_i + step;

  logic [AW-1:0] diff;
  assign diff = addr_o - ptr_i;

  always_comb begin
    assert_short_window_R6: assert (mode_i != MODE_SHORT ||
      (&diff[AW-1:SHORT_W-1]) || !(|diff[AW-1:SHORT_W-1]));
  end
endmodule

// File: rtl/eag_stack.sv
module eag_stack #(
  parameter int AW         = 16,
  parameter int WORD_BYTES = 2
) (
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [AW-1:0] sp_i,
  output logic [AW-1:0] addr_o,
  output logic [AW-1:0] sp_nxt_o
);
  logic [AW-1:0] sp_dec;
  logic [AW-1:0] sp_inc;

  assign sp_dec   = sp_i - AW'(WORD_BYTES);
  assign sp_inc   = sp_i + AW'(WORD_BYTES);
  // push pre-decrements, pop post-increments
  assign addr_o   = push_i ? sp_dec : sp_i;
  assign sp_nxt_o = push_i ? sp_dec : (pop_i ? sp_inc : sp_i);

  always_comb begin
    assert_push_addr_is_new_sp_R8: assert (!push_i || addr_o == sp_nxt_o);
  end
endmodule

// File: rtl/eag_top.sv
module eag_top
  import eag_pkg::*;
#(
  parameter int              AW         = 16,
  parameter int              SEL_W      = 8,
  parameter int              SHORT_W    = 8,
  parameter int              WORD_BYTES = 2,
  parameter logic [SEL_W-1:0] SP_SEL    = 8'h18
) (
  input  logic [2:0]       mode_i,
  input  logic             size_i,
  input  logic [SEL_W-1:0] reg_sel_i,
  input  logic [AW-1:0]    ptr_i,
  input  logic [AW-1:0]    field_i,
  input  logic [AW-1:0]    sp_i,
  output logic [AW-1:0]    addr_o,
  output logic             imm_valid_o,
  output logic [AW-1:0]    ptr_wb_o,
  output logic             ptr_wb_en_o,
  output logic [AW-1:0]    sp_o,
  output logic             sp_we_o,
  output logic             align_err_o
);
  localparam int ZPAD_SEL = AW - SEL_W;
  localparam int ZPAD_B   = AW - BYTE_W;

  mode_e         mode;
  logic          is_push, is_pop, is_stack, is_inc;
  logic [AW-1:0] idx_addr, idx_inc;
  logic [AW-1:0] stk_addr, stk_sp;
  logic [AW-1:0] imm_val;

  assign mode     = mode_e'(mode_i);
  assign is_push  = (mode == MODE_PUSH);
  assign is_pop   = (mode == MODE_POP);
  assign is_stack = is_push | is_pop;
  assign is_inc   = (mode == MODE_INDINC);

  eag_align_chk #(.SEL_W(SEL_W)) u_align (
    .mode_i   (mode),
    .size_i   (size_i),
    .sel_i    (reg_sel_i),
    .sp_lsb_i (sp_i[0]),
    .err_o    (align_err_o)
  );

  eag_index_add #(.AW(AW), .SHORT_W(SHORT_W), .WORD_BYTES(WORD_BYTES)) u_index (
    .mode_i  (mode),
    .size_i  (size_i),
    .ptr_i   (ptr_i),
    .field_i (field_i),
    .addr_o  (idx_addr),
    .inc_o   (idx_inc)
  );

  eag_stack #(.AW(AW), .WORD_BYTES(WORD_BYTES)) u_stack (
    .push_i   (is_push),
    .pop_i    (is_pop),
    .sp_i     (sp_i),
    .addr_o   (stk_addr),
    .sp_nxt_o (stk_sp)
  );

  assign imm_val = size_i ? field_i : {{ZPAD_B{1'b0}}, field_i[BYTE_W-1:0]};

  always_comb begin
    unique case (mode)
      MODE_DIRECT:          addr_o = {{ZPAD_SEL{1'b0}}, reg_sel_i};
      MODE_IMM:             addr_o = imm_val;
      MODE_IND, MODE_INDINC,
      MODE_SHORT, MODE_LONG: addr_o = idx_addr;
      default:              addr_o = stk_addr;
    endcase
  end

  assign imm_valid_o = (mode == MODE_IMM);
  assign ptr_wb_o    = idx_inc;
  assign ptr_wb_en_o = is_inc & ~align_err_o;
  // post-increment of the stack pointer's own register aliases onto SP
  assign sp_we_o     = ~align_err_o & (is_stack | (is_inc & (reg_sel_i == SP_SEL)));
  assign sp_o        = !sp_we_o ? sp_i : (is_stack ? stk_sp : idx_inc);

  always_comb begin
    assert_err_blocks_wb_R11: assert (!align_err_o || (!ptr_wb_en_o && !sp_we_o && sp_o == sp_i));
    assert_imm_no_side_effect_R3: assert (!imm_valid_o || (!ptr_wb_en_o && !sp_we_o));
    assert_stack_step_R9: assert (!(sp_we_o && is_pop) || (sp_o - sp_i) == AW'(WORD_BYTES));
    assert_sp_alias_R12: assert (!(sp_we_o && is_inc) || (ptr_wb_en_o && sp_o == ptr_wb_o));
  end
endmodule

// File: tb/eag_top_bench.sv
module eag_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  mode;
  logic        size;
  logic [7:0]  sel;
  logic [15:0] ptr, fld, sp;
  logic [15:0] addr, ptr_wb, sp_nxt;
  logic        imm_v, wb_en, sp_we, err;
  int          checks = 0;
  int          failures = 0;
  bit          done = 0;

  always #10 clk = ~clk;

  eag_top u_eag_top (
    .mode_i(mode), .size_i(size), .reg_sel_i(sel), .ptr_i(ptr), .field_i(fld), .sp_i(sp),
    .addr_o(addr), .imm_valid_o(imm_v), .ptr_wb_o(ptr_wb), .ptr_wb_en_o(wb_en),
    .sp_o(sp_nxt), .sp_we_o(sp_we), .align_err_o(err)
  );

  typedef struct packed {
    logic [2:0]  mode;
    logic        size;
    logic [7:0]  sel;
    logic [15:0] ptr;
    logic [15:0] fld;
    logic [15:0] sp;
    logic [15:0] e_addr;
    logic        e_imm;
    logic        e_wben;
    logic [15:0] e_wb;
    logic        e_spwe;
    logic [15:0] e_sp;
    logic        e_err;
    logic [3:0]  req;
  } tv_t;

  localparam int NV = 20;
  localparam tv_t VEC [NV] = '{
    '{3'd0,1'b1,8'h1A,16'h0000,16'h0000,16'h0100,16'h001A,1'b0,1'b0,16'h0000,1'b0,16'h0100,1'b0,4'd1},  // R1
    '{3'd0,1'b0,8'h1B,16'h0000,16'h0000,16'h0100,16'h001B,1'b0,1'b0,16'h0000,1'b0,16'h0100,1'b0,4'd2},  // R2 byte odd ok
    '{3'd0,1'b1,8'h1B,16'h0000,16'h0000,16'h0100,16'h001B,1'b0,1'b0,16'h0000,1'b0,16'h0100,1'b1,4'd2},  // R2 word odd
    '{3'd1,1'b0,8'h00,16'h0000,16'hABCD,16'h0100,16'h00CD,1'b1,1'b0,16'h0000,1'b0,16'h0100,1'b0,4'd3},  // R3 byte
    '{3'd1,1'b1,8'h00,16'h0000,16'hABCD,16'h0100,16'hABCD,1'b1,1'b0,16'h0000,1'b0,16'h0100,1'b0,4'd3},  // R3 word
    '{3'd2,1'b1,8'h20,16'h3000,16'h0000,16'h0100,16'h3000,1'b0,1'b0,16'h0000,1'b0,16'h0100,1'b0,4'd4},  // R4
    '{3'd3,1'b1,8'h20,16'h3000,16'h0000,16'h0100,16'h3000,1'b0,1'b1,16'h3002,1'b0,16'h0100,1'b0,4'd5},  // R5 word
    '{3'd3,1'b0,8'h22,16'h4001,16'h0000,16'h0100,16'h4001,1'b0,1'b1,16'h4002,1'b0,16'h0100,1'b0,4'd5},  // R5 byte
    '{3'd4,1'b1,8'h24,16'h1000,16'h0080,16'h0100,16'h0F80,1'b0,1'b0,16'h0000,1'b0,16'h0100,1'b0,4'd6},  // R6 -128
    '{3'd4,1'b1,8'h24,16'h1000,16'hFF7F,16'h0100,16'h107F,1'b0,1'b0,16'h0000,1'b0,16'h0100,1'b0,4'd6},  // R6 +127
    '{3'd5,1'b1,8'h24,16'h1000,16'h0080,16'h0100,16'h1080,1'b0,1'b0,16'h0000,1'b0,16'h0100,1'b0,4'd7},  // R7
    '{3'd5,1'b0,8'h24,16'hF000,16'h2000,16'h0100,16'h1000,1'b0,1'b0,16'h0000,1'b0,16'h0100,1'b0,4'd10}, // R10
    '{3'd6,1'b1,8'h00,16'h0000,16'h0000,16'h0100,16'h00FE,1'b0,1'b0,16'h0000,1'b1,16'h00FE,1'b0,4'd8},  // R8
    '{3'd7,1'b1,8'h00,16'h0000,16'h0000,16'h0100,16'h0100,1'b0,1'b0,16'h0000,1'b1,16'h0102,1'b0,4'd9},  // R9
    '{3'd6,1'b1,8'h00,16'h0000,16'h0000,16'h0000,16'hFFFE,1'b0,1'b0,16'h0000,1'b1,16'hFFFE,1'b0,4'd10}, // R10 push wrap
    '{3'd3,1'b1,8'h21,16'h3000,16'h0000,16'h0100,16'h3000,1'b0,1'b0,16'h0000,1'b0,16'h0100,1'b1,4'd11}, // R11 odd ptr
    '{3'd7,1'b1,8'h00,16'h0000,16'h0000,16'h0101,16'h0101,1'b0,1'b0,16'h0000,1'b0,16'h0101,1'b1,4'd11}, // R11 odd sp
    '{3'd3,1'b1,8'h18,16'h0200,16'h0000,16'h0200,16'h0200,1'b0,1'b1,16'h0202,1'b1,16'h0202,1'b0,4'd12}, // R12
    '{3'd3,1'b1,8'h20,16'hFFFE,16'h0000,16'h0100,16'hFFFE,1'b0,1'b1,16'h0000,1'b0,16'h0100,1'b0,4'd10}, // R10 inc wrap
    '{3'd2,1'b0,8'h23,16'h5000,16'h0000,16'h0100,16'h5000,1'b0,1'b0,16'h0000,1'b0,16'h0100,1'b1,4'd2}   // R2 pointer odd
  };

  task automatic apply(input logic [2:0] m, input logic s, input logic [7:0] r,
                       input logic [15:0] p, input logic [15:0] f, input logic [15:0] k);
    @(posedge clk);
    #2;
    mode = m; size = s; sel = r; ptr = p; fld = f; sp = k;
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    mode = 3'd0; size = 1'b0; sel = 8'h00; ptr = '0; fld = '0; sp = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // idle state with all-zero inputs: direct byte selector 0, R1
    @(negedge clk);
    chk("R1 idle addr", addr, 16'h0000);
    chk("R1 idle flags", {12'h0, imm_v, wb_en, sp_we, err}, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      tv_t v;
      string t;
      v = VEC[i];
      apply(v.mode, v.size, v.sel, v.ptr, v.fld, v.sp);
      t = $sformatf("R%0d vec%0d", v.req, i);
      chk({t, " addr"}, addr, v.e_addr);
      chk({t, " flags"}, {12'h0, imm_v, wb_en, sp_we, err}, {12'h0, v.e_imm, v.e_wben, v.e_spwe, v.e_err});
      chk({t, " sp"}, sp_nxt, v.e_sp);
      if (v.e_wben) chk({t, " wb"}, ptr_wb, v.e_wb);
    end

    // R6 sweep of every displacement with upper field bits set to junk
    for (int d = 0; d < 256; d++) begin
      logic [7:0] db;
      db = 8'(d);
      apply(3'd4, 1'b1, 8'h30, 16'h8000, {8'h5A, db}, 16'h0100);
      chk("R6 sweep", addr, 16'h8000 + {{8{db[7]}}, db});
    end

    // R12 negative case: post-increment on a different selector leaves SP alone
    apply(3'd3, 1'b1, 8'h1A, 16'h0200, 16'h0000, 16'h0300);
    chk("R12 other sel sp_we", {15'h0, sp_we}, 16'h0000);
    chk("R12 other sel sp", sp_nxt, 16'h0300);

    // R11 alias case blocked by odd selector 19H
    apply(3'd3, 1'b1, 8'h19, 16'h0200, 16'h0000, 16'h0200);
    chk("R11 alias blocked", {14'h0, wb_en, sp_we}, 16'h0000);

    // R3 byte immediate ignores upper field bits
    apply(3'd1, 1'b0, 8'h00, 16'h0000, 16'hFF00, 16'h0100);
    chk("R3 byte imm zero", addr, 16'h0000);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule